// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the linked chain of extended capability headers kept in the upper part of a 4 KB configuration space. The space sits in an external word-addressed RAM with a one-cycle synchronous read. A command starts either a search or an append. A search follows the 12-bit next pointers from offset 0x100 until it reaches a header with the requested ID or the end of the chain. A search for ID 0 returns the tail. An append links a new header behind the current tail, or rewrites the header at 0x100 in place.

Every pointer the walk is about to follow is checked for range and alignment. A step limit stops a chain that loops back on itself. The result offset, the offset of the preceding header and an error flag are registered. They change only in the cycle in which the one-cycle done pulse is high.

Top module: `cfgx_chain_walker`

## Requirements
- R1: A header word holds the ID in bits 15:0, the version in bits 19:16 and the next offset in bits 31:20. If the word at 0x100 is zero, a search returns result 0 and previous 0, with no error.
- R2: A search stops at the first visited header whose ID equals the requested ID. It returns that header's offset as the result and the offset visited before it as previous, which is 0 for the header at 0x100.
- R3: When a search reaches a header with next offset 0 and no ID has matched, it returns result 0 and gives that last header's offset as previous. A request for ID 0 therefore yields the tail.
- R4: Before a next pointer is followed, it is checked. If it is below 0x100, above 0xFF8 or not a multiple of 4, the command ends with error set and with result and previous both 0. No read is ever issued outside 0x100..0xFF8.
- R5: If the walk would continue after decoding 1024 headers, the command ends with an error.
- R6: op=1 is an append. An append at offset 0x100 reads the header there and rewrites it with the new ID and version. The old next offset is kept. The command returns result 0x100 and previous 0.
- R7: An append at any other offset finds the tail and rewrites the tail's next field to the new offset, keeping the tail's ID and version. It then writes the new header with next 0. The command returns result = new offset and previous = tail offset.
- R8: An append is rejected with an error, in the cycle after the command and with no memory write, if any of these holds: the offset is below 0x100, the offset is not a multiple of 4, the size is below 8, or offset plus size is 0x1000 or more.
- R9: An append at an offset other than 0x100 ends in error, with no write, when the chain is empty or a header with ID 0 lies on the way to the tail.
- R10: Each header visited costs one read cycle and one wait cycle. For a search that decodes N headers, done pulses for one cycle 2N clocks after the start edge. For an append at 0x100 the pulse comes 2 clocks after the start edge, and for a linking append 2N+1 clocks after it. The outputs hold their values until the next done.
- R11: start (op=0 search, op=1 append) is ignored while a command is in progress.
- R12: After reset, done, err, result and previous are 0 and no memory access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only when idle |
| op | input | 1 | 0 = search, 1 = append |
| cap_id | input | 16 | Requested or new capability ID |
| cap_ver | input | 4 | Version for an appended header |
| cap_off | input | 12 | Byte offset of an appended header |
| cap_size | input | 12 | Byte size of an appended capability |
| mem_rd | output | 1 | Read request to configuration RAM |
| mem_wr | output | 1 | Write request to configuration RAM |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command failed |
| found_off | output | 12 | Result offset |
| prev_off | output | 12 | Offset of the preceding (or tail) header |

## Verification
On every cycle the assertions check the following: reads stay inside the legal window; each read is followed by a wait cycle; reads and writes never coincide; an error always carries zero offsets; the outputs move only with done; and the step counter stays within its limit. Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural chain model each clock. These are which header is returned, the exact completion cycle for chains of different lengths, the preserved next pointer on a base append, the two-word link on a tail append, rejected parameters, broken pointers, a looping chain, and a start pulse arriving mid-walk.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int OFF_W  = 12;
  localparam int ID_W   = 16;
  localparam int VER_W  = 4;
  localparam int HDR_W  = OFF_W + VER_W + ID_W;
  localparam int WADR_W = OFF_W - 2;

  typedef struct packed {
    logic [OFF_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } cap_hdr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DEC, ST_LINK} walk_st_e;
endpackage

// File: rtl/cfgx_ptr_check.sv
module cfgx_ptr_check #(
  parameter int           W  = 12,
  parameter logic [W-1:0] LO = 'h100,
  parameter logic [W-1:0] HI = 'hFF8
) (
  input  logic [W-1:0] ptr,
  output logic         ok
);
  assign ok = (ptr >= LO) && (ptr <= HI) && (ptr[1:0] == 2'b00);
endmodule

// File: rtl/cfgx_step_ctr.sv
module cfgx_step_ctr #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt >= CW'(LIMIT - 1));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/cfgx_chain_walker.sv
module cfgx_chain_walker
  import cfgx_pkg::*;
#(
  parameter int               MAX_STEPS = 1024,
  parameter logic [OFF_W-1:0] BASE_OFF  = 'h100,
  parameter logic [OFF_W-1:0] LAST_OFF  = 'hFF8,
  parameter int               MIN_SIZE  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op,
  input  logic [ID_W-1:0]   cap_id,
  input  logic [VER_W-1:0]  cap_ver,
  input  logic [OFF_W-1:0]  cap_off,
  input  logic [OFF_W-1:0]  cap_size,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WADR_W-1:0] mem_addr,
  output logic [HDR_W-1:0]  mem_wdata,
  input  logic [HDR_W-1:0]  mem_rdata,
  output logic              done,
  output logic              err,
  output logic [OFF_W-1:0]  found_off,
  output logic [OFF_W-1:0]  prev_off
);
  localparam int SPACE = 1 << OFF_W;

  walk_st_e         state;
  logic             op_q, first_q;
  logic [ID_W-1:0]  id_q;
  logic [VER_W-1:0] ver_q;
  logic [OFF_W-1:0] off_q, cur_q, prev_q;

  cap_hdr_t hdr;
  logic     off_ok, nxt_ok, append_ok, last_step;
  logic     base_append, empty, hit, at_tail, walk_go;

  assign hdr = cap_hdr_t'(mem_rdata);

  cfgx_ptr_check #(.W(OFF_W), .LO(BASE_OFF), .HI(LAST_OFF)) i_off_chk (
    .ptr(cap_off), .ok(off_ok));
  cfgx_ptr_check #(.W(OFF_W), .LO(BASE_OFF), .HI(LAST_OFF)) i_nxt_chk (
    .ptr(hdr.nxt), .ok(nxt_ok));

  assign append_ok = off_ok && (cap_size >= OFF_W'(MIN_SIZE)) &&
                     (({1'b0, cap_off} + {1'b0, cap_size}) < (OFF_W+1)'(SPACE));

  assign base_append = first_q && op_q && (off_q == BASE_OFF);
  assign empty       = first_q && (mem_rdata == '0);
  assign hit         = hdr.id == (op_q ? ID_W'(0) : id_q);
  assign at_tail     = hdr.nxt == '0;
  assign walk_go     = !base_append && !empty && !hit && !at_tail && nxt_ok && !last_step;

  cfgx_step_ctr #(.LIMIT(MAX_STEPS)) i_steps (
    .clk(clk), .rst(rst),
    .clr(state == ST_IDLE && start),
    .inc(state == ST_DEC && walk_go),
    .last(last_step));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  done <= 1'b0;  err <= 1'b0;
      found_off <= '0;   prev_off <= '0;
      mem_rd <= 1'b0;    mem_wr <= 1'b0;
      mem_addr <= '0;    mem_wdata <= '0;
      op_q <= 1'b0;      first_q <= 1'b0;
      id_q <= '0;        ver_q <= '0;
      off_q <= '0;       cur_q <= '0;  prev_q <= '0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_q <= op;  id_q <= cap_id;  ver_q <= cap_ver;  off_q <= cap_off;
          cur_q <= BASE_OFF;  prev_q <= '0;  first_q <= 1'b1;
          if (op && !append_ok) begin
            done <= 1'b1;  err <= 1'b1;  found_off <= '0;  prev_off <= '0;
          end else begin
            mem_rd   <= 1'b1;
            mem_addr <= BASE_OFF[OFF_W-1:2];
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: state <= ST_DEC;
        ST_DEC: begin
          first_q <= 1'b0;
          state   <= ST_IDLE;
          if (base_append) begin
            mem_wr    <= 1'b1;
            mem_addr  <= BASE_OFF[OFF_W-1:2];
            mem_wdata <= {hdr.nxt, ver_q, id_q};
            done <= 1'b1;  err <= 1'b0;  found_off <= BASE_OFF;  prev_off <= '0;
          end else if (empty) begin
            done <= 1'b1;  err <= op_q;  found_off <= '0;  prev_off <= '0;
          end else if (hit) begin
            done <= 1'b1;  err <= op_q;
            found_off <= op_q ? '0 : cur_q;
            prev_off  <= op_q ? '0 : prev_q;
          end else if (at_tail) begin
            if (op_q) begin
              mem_wr    <= 1'b1;
              mem_addr  <= cur_q[OFF_W-1:2];
              mem_wdata <= {off_q, hdr.ver, hdr.id};
              prev_q    <= cur_q;
              state     <= ST_LINK;
            end else begin
              done <= 1'b1;  err <= 1'b0;  found_off <= '0;  prev_off <= cur_q;
            end
          end else if (!walk_go) begin
            done <= 1'b1;  err <= 1'b1;  found_off <= '0;  prev_off <= '0;
          end else begin
            prev_q   <= cur_q;
            cur_q    <= hdr.nxt;
            mem_rd   <= 1'b1;
            mem_addr <= hdr.nxt[OFF_W-1:2];
            state    <= ST_WAIT;
          end
        end
        ST_LINK: begin
          mem_wr    <= 1'b1;
          mem_addr  <= off_q[OFF_W-1:2];
          mem_wdata <= {OFF_W'(0), ver_q, id_q};
          done <= 1'b1;  err <= 1'b0;  found_off <= off_q;  prev_off <= prev_q;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr >= BASE_OFF[OFF_W-1:2]) && (mem_addr <= LAST_OFF[OFF_W-1:2]));

  // R4
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (found_off == '0) && (prev_off == '0));

  // R10
  rd_wait_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(found_off) && $stable(prev_off) && $stable(err));

  // R7
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

// File: tb/test_cfgx_chain_walker.sv
`timescale 1ns/1ps
module test_cfgx_chain_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, op = 1'b0;
  logic [15:0] cap_id = '0;
  logic [3:0]  cap_ver = '0;
  logic [11:0] cap_off = '0, cap_size = '0;
  logic        mem_rd, mem_wr;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        done, err;
  logic [11:0] found_off, prev_off;

  logic [31:0] mem [0:1023];
  logic        tb_clr = 1'b0, tb_we = 1'b0;
  logic [9:0]  tb_a = '0;
  logic [31:0] tb_d = '0;
  int n_cmp = 0, n_bad = 0, wr_count = 0, wd = 0;

  always #4 clk = ~clk;

  cfgx_chain_walker i_cfgx_chain_walker (
    .clk(clk), .rst(rst), .start(start), .op(op), .cap_id(cap_id),
    .cap_ver(cap_ver), .cap_off(cap_off), .cap_size(cap_size),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .err(err),
    .found_off(found_off), .prev_off(prev_off));

  always @(posedge clk) begin
    if (tb_clr) for (int i = 0; i < 1024; i++) mem[i] <= '0;
    else if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) wr_count++;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        chk(1'b0, "watchdog", wd, 150000);
        summary();
      end
    end
  end

  task automatic mem_clear();
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
  endtask

  task automatic mem_put(input int off, input logic [31:0] v);
    @(negedge clk); tb_we = 1'b1; tb_a = 10'(off >> 2); tb_d = v;
    @(negedge clk); tb_we = 1'b0;
  endtask

  // Behavioural chain model: number of headers decoded, result, previous, error.
  task automatic ref_walk(input logic [15:0] id, output int found, output int prev,
                          output int n, output bit e, output bit empty);
    logic [31:0] h;
    int cur, prv, nx;
    n = 1; e = 0; empty = 0; found = 0; prev = 0;
    h = mem[64];
    if (h == 0) begin empty = 1; return; end
    cur = 256; prv = 0;
    while (1) begin
      if (h[15:0] == id) begin found = cur; prev = prv; return; end
      nx = int'(h[31:20]);
      if (nx == 0) begin found = 0; prev = cur; return; end
      if (nx < 256 || nx > 4088 || (nx % 4) != 0 || n >= 1024) begin
        e = 1; found = 0; prev = 0; return;
      end
      prv = cur; cur = nx; h = mem[cur / 4]; n++;
    end
  endtask

  task automatic run_cmd(input bit o, input logic [15:0] id, input logic [3:0] ver,
                         input int off, input int size, input string tag, input bit poke);
    int d, ef, ep, n, ewr, w0, rf, rp;
    bit ee, re, rempty;
    logic [31:0] tail_old, base_old;
    ee = 0; ef = 0; ep = 0; ewr = 0; tail_old = '0;
    base_old = mem[64];
    if (!o) begin
      ref_walk(id, ef, ep, n, ee, rempty);
      d = 2 * n;
    end else if (off < 256 || (off % 4) != 0 || size < 8 || off + size >= 4096) begin
      d = 0; ee = 1;
    end else if (off == 256) begin
      d = 2; ef = 256; ep = 0; ewr = 1;
    end else begin
      ref_walk(16'h0, rf, rp, n, re, rempty);
      if (re)          begin d = 2 * n; ee = 1; end
      else if (rempty) begin d = 2; ee = 1; end
      else if (rf != 0) begin d = 2 * n; ee = 1; end
      else begin
        d = 2 * n + 1; ef = off; ep = rp; ewr = 2;
        tail_old = mem[rp / 4];
      end
    end
    w0 = wr_count;
    @(negedge clk);
    start = 1'b1; op = o; cap_id = id; cap_ver = ver;
    cap_off = 12'(off); cap_size = 12'(size);
    for (int k = 0; k <= d + 1; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (poke && k == 2) begin start = 1'b1; op = 1'b0; cap_id = 16'h0003; end
      if (poke && k == 3) start = 1'b0;
      chk(done === (k == d), {tag, " done timing"}, int'(done), int'(k == d));
      if (k == d || k == d + 1) begin
        chk(err === ee, {tag, " err"}, int'(err), int'(ee));
        chk(found_off === 12'(ef), {tag, " result offset"}, int'(found_off), ef);
        chk(prev_off === 12'(ep), {tag, " previous offset"}, int'(prev_off), ep);
      end
    end
    chk(wr_count - w0 == ewr, {tag, " write count"}, wr_count - w0, ewr);
    if (ewr == 1)
      chk(mem[64] === {base_old[31:20], ver, id}, {tag, " base header"},
          int'(mem[64]), int'({base_old[31:20], ver, id}));
    if (ewr == 2) begin
      chk(mem[ep / 4] === {12'(off), tail_old[19:0]}, {tag, " tail link"},
          int'(mem[ep / 4]), int'({12'(off), tail_old[19:0]}));
      chk(mem[off / 4] === {12'h0, ver, id}, {tag, " new header"},
          int'(mem[off / 4]), int'({12'h0, ver, id}));
    end
  endtask

  initial begin
    mem_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(done === 1'b0 && err === 1'b0, "R12 flags", int'({done, err}), 0);
    chk(found_off === '0 && prev_off === '0, "R12 offsets", int'(found_off), 0);
    chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R12 memory idle", int'({mem_rd, mem_wr}), 0);

    // R1 empty chain
    run_cmd(1'b0, 16'h0005, 4'h0, 0, 0, "R1 empty search", 1'b0);

    // Three-header chain: 0x100 -> 0x140 -> 0x200
    mem_put(12'h100, {12'h140, 4'h1, 16'h0003});
    mem_put(12'h140, {12'h200, 4'h1, 16'h000B});
    mem_put(12'h200, {12'h000, 4'h2, 16'h0010});
    run_cmd(1'b0, 16'h0003, 4'h0, 0, 0, "R2 first header", 1'b0);
    run_cmd(1'b0, 16'h000B, 4'h0, 0, 0, "R2 middle header", 1'b0);
    run_cmd(1'b0, 16'h0010, 4'h0, 0, 0, "R2 last header R10", 1'b0);
    run_cmd(1'b0, 16'h0077, 4'h0, 0, 0, "R3 absent id", 1'b0);
    run_cmd(1'b0, 16'h0000, 4'h0, 0, 0, "R3 tail request", 1'b0);

    // R7 link a new header at 0x300
    run_cmd(1'b1, 16'h000E, 4'h2, 12'h300, 16, "R7 tail append", 1'b0);
    run_cmd(1'b0, 16'h000E, 4'h0, 0, 0, "R7 search appended", 1'b0);

    // R8 rejected parameters
    run_cmd(1'b1, 16'h0020, 4'h1, 12'h0C0, 16, "R8 low offset", 1'b0);
    run_cmd(1'b1, 16'h0020, 4'h1, 12'h302, 16, "R8 misaligned", 1'b0);
    run_cmd(1'b1, 16'h0020, 4'h1, 12'h400, 4, "R8 small size", 1'b0);
    run_cmd(1'b1, 16'h0020, 4'h1, 12'hFF8, 8, "R8 past end", 1'b0);

    // R6 rewrite base header, next pointer kept
    run_cmd(1'b1, 16'h0021, 4'h3, 12'h100, 8, "R6 base append", 1'b0);
    run_cmd(1'b0, 16'h0010, 4'h0, 0, 0, "R6 chain intact", 1'b0);

    // R11 start pulse mid-walk is ignored
    run_cmd(1'b0, 16'h000E, 4'h0, 0, 0, "R11 busy start", 1'b1);

    // R4 broken pointers
    mem_put(12'h300, {12'h0C0, 4'h2, 16'h000E});
    run_cmd(1'b0, 16'h0099, 4'h0, 0, 0, "R4 low pointer", 1'b0);
    mem_put(12'h300, {12'h302, 4'h2, 16'h000E});
    run_cmd(1'b0, 16'h0099, 4'h0, 0, 0, "R4 misaligned pointer", 1'b0);
    mem_put(12'h300, {12'hFFC, 4'h2, 16'h000E});
    run_cmd(1'b0, 16'h0099, 4'h0, 0, 0, "R4 high pointer", 1'b0);
    run_cmd(1'b1, 16'h0031, 4'h1, 12'h500, 8, "R4 append over bad link", 1'b0);

    // R9 ID 0 header in the way, then empty chain
    mem_put(12'h300, {12'h000, 4'h2, 16'h0000});
    run_cmd(1'b1, 16'h0031, 4'h1, 12'h500, 8, "R9 zero id on path", 1'b0);
    mem_clear();
    run_cmd(1'b1, 16'h0031, 4'h1, 12'h500, 8, "R9 empty chain", 1'b0);
    run_cmd(1'b1, 16'h0032, 4'h4, 12'h100, 8, "R6 base on empty", 1'b0);

    // R5 loop between two headers
    mem_clear();
    mem_put(12'h100, {12'h200, 4'h1, 16'h0001});
    mem_put(12'h200, {12'h100, 4'h1, 16'h0002});
    run_cmd(1'b0, 16'h0099, 4'h0, 0, 0, "R5 looping chain", 1'b0);

    summary();
  end
endmodule